// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is an eight-stage shift register, and its length can be set by a parameter. Data enters it in parallel and leaves it in serial form. A fast system clock runs the whole block. The slow shift clock, the clock-inhibit and the active-low load control arrive as ordinary input signals. Every input passes through a two-flop synchronizer before any logic uses it. The synchronized shift clock and inhibit are ORed into a single gate signal. A shift happens when that gate goes from low to high, so either input can serve as the clock and the other as the inhibit.

While the load control is low, the stages take the parallel inputs on every system clock. Loading takes priority over any clock activity and over the serial input. While the load control is high, each qualifying gate edge moves the data one stage toward the last stage, and the serial input enters the first stage. The last stage is driven out in true and complemented form.

Top module: `pss_gated_piso`

## Requirements
- R1: After the active-low synchronous reset, every stage is 0, so `q_last`=0 and `q_last_n`=1. No shift follows directly on reset release, even when the gate is high.
- R2: While load is low, stage k takes `par_in[k]`. Stage 0 is the first stage and stage WIDTH-1 drives `q_last`.
- R3: While load is low, changes on `shift_clk`, `clk_inh` and `ser_in` have no effect on the stages.
- R4: While load stays low, the stages follow changes on `par_in` on every system clock.
- R5: With load high and `clk_inh` low, a low-to-high change of `shift_clk` moves the register by one stage. Stage 0 takes `ser_in` and stage k takes the old stage k-1.
- R6: While either `shift_clk` or `clk_inh` is held high, changes on the other input cause no shift.
- R7: With load high and `shift_clk` low, a low-to-high change of `clk_inh` also shifts by one stage.
- R8: With load high and no low-to-high change of the combined gate, the stages keep their contents.
- R9: `q_last_n` is always the complement of `q_last`.
- R10: An input change applied between system clock edges shows at the outputs after the third following rising edge, and not before.
- R11: After a load and N shifts, `q_last` shows `par_in[WIDTH-1-N]` for N < WIDTH. After that it shows the serial bits in the order they were shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_in | input | WIDTH | Parallel data, bit k feeds stage k |
| ser_in | input | 1 | Serial data into stage 0 |
| load_n | input | 1 | Low: load the parallel data; high: shifting allowed |
| shift_clk | input | 1 | Shift clock, one input of the OR gate |
| clk_inh | input | 1 | Clock-inhibit, the other input of the OR gate |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The hardest case to reach is a gate edge that must not shift. One example is the inhibit rising while the shift clock is already high. Another is the inhibit being lowered while the clock is high. In both cases the only sign of a mistake is a one-stage slip that appears many cycles later at the last stage. The bench first loads a known byte and then runs these inhibit sequences. It next shifts the byte out in full, so a missing shift or an extra one shows up as a wrong bit. A long stretch of random pin activity follows, and a queue-based reference model that includes the synchronizer delay compares the outputs on every cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } pss_op_e;

    // Load wins over any clock edge.
    function automatic pss_op_e pss_pick_op(input logic load_n, input logic edge_seen);
        if (!load_n)
            return OP_LOAD;
        else if (edge_seen)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n)
                chain_q[i] <= RST_VAL;
            else
                chain_q[i] <= chain_d[i];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pss_edge.sv
module pss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_s,
    input  logic inh_s,
    output logic edge_seen
);

    typedef struct packed {
        logic prev_gate;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        gate;

    always_comb begin
        gate           = ck_s | inh_s;
        st_d.prev_gate = gate;
        edge_seen      = gate & ~st_q.prev_gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.prev_gate <= 1'b1;
        else
            st_q <= st_d;
    end

    // R6: a gate edge yields one pulse only
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !edge_seen);

    // R1: no pulse on the first cycle after reset
    a_r1_no_pulse_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !edge_seen);

endmodule

// File: rtl/pss_shifter.sv
module pss_shifter
    import pss_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n_s,
    input  logic             edge_seen,
    input  logic             ser_s,
    input  logic [WIDTH-1:0] par_s,
    output logic             last,
    output logic             last_n
);

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } shift_state_t;

    shift_state_t st_d, st_q;
    pss_op_e      op;

    always_comb begin
        op   = pss_pick_op(load_n_s, edge_seen);
        st_d = st_q;
        case (op)
            OP_LOAD:  st_d.stages = par_s;
            OP_SHIFT: st_d.stages = {st_q.stages[WIDTH-2:0], ser_s};
            default:  st_d.stages = st_q.stages;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.stages <= '0;
        else
            st_q <= st_d;
    end

    assign last   = st_q.stages[WIDTH-1];
    assign last_n = ~st_q.stages[WIDTH-1];

    // R1: cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> st_q.stages == '0);

    // R2: load takes parallel data
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> st_q.stages == $past(par_s));

    // R5: one-stage move with serial entry
    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && edge_seen) |=>
            (st_q.stages[0] == $past(ser_s)) &&
            (st_q.stages[WIDTH-1:1] == $past(st_q.stages[WIDTH-2:0])));

    // R8: hold without an edge
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !edge_seen) |=> $stable(st_q.stages));

endmodule

// File: rtl/pss_gated_piso.sv
module pss_gated_piso #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             shift_clk,
    input  logic             clk_inh,
    output logic             q_last,
    output logic             q_last_n
);

    localparam int BUNDLE_W = WIDTH + 4;
    // idle: ser 0, load_n 1, shift_clk 1, clk_inh 0
    localparam logic [BUNDLE_W-1:0] BUNDLE_RST = {{WIDTH{1'b0}}, 4'b0110};

    logic [BUNDLE_W-1:0] bundle_raw;
    logic [BUNDLE_W-1:0] bundle_s;
    logic [WIDTH-1:0]    par_s;
    logic                ser_s;
    logic                load_n_s;
    logic                ck_s;
    logic                inh_s;
    logic                edge_seen;

    assign bundle_raw = {par_in, ser_in, load_n, shift_clk, clk_inh};

    pss_sync #(
        .W       (BUNDLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUNDLE_RST)
    ) u_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .din   (bundle_raw),
        .dout  (bundle_s)
    );

    assign {par_s, ser_s, load_n_s, ck_s, inh_s} = bundle_s;

    pss_edge u_edge (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .ck_s      (ck_s),
        .inh_s     (inh_s),
        .edge_seen (edge_seen)
    );

    pss_shifter #(
        .WIDTH (WIDTH)
    ) u_shift (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .load_n_s  (load_n_s),
        .edge_seen (edge_seen),
        .ser_s     (ser_s),
        .par_s     (par_s),
        .last      (q_last),
        .last_n    (q_last_n)
    );

    // R9: outputs complementary
    a_r9_complement: assert property (@(posedge sys_clk) disable iff (!rst_n)
        q_last_n != q_last);

endmodule

// File: tb/sim_pss_gated_piso.sv
module sim_pss_gated_piso;

    logic       sys_clk = 1'b0;
    logic       rst_n;
    logic [7:0] par_in;
    logic       ser_in, load_n, shift_clk, clk_inh;
    logic       q_last, q_last_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string tag      = "R1";

    always #10 sys_clk = ~sys_clk;

    pss_gated_piso u0 (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .load_n   (load_n),
        .shift_clk(shift_clk),
        .clk_inh  (clk_inh),
        .q_last   (q_last),
        .q_last_n (q_last_n)
    );

    task automatic chk(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: input snapshots delayed through a queue
    localparam logic [11:0] SNAP_RST = {8'h00, 4'b0110};
    logic [11:0] pipe [$];
    logic [7:0]  m_reg  = 8'h00;
    logic        m_prev = 1'b1;

    always @(negedge sys_clk) begin
        if (!done) begin
            logic [11:0] cur, s;
            logic gate;
            cur = {par_in, ser_in, load_n, shift_clk, clk_inh};
            if (!rst_n) begin
                m_reg  = 8'h00;
                m_prev = 1'b1;
                pipe.delete();
                pipe.push_back(SNAP_RST);
                pipe.push_back(SNAP_RST);
            end else begin
                s = pipe.pop_front();
                gate = s[1] | s[0];
                if (!s[2])
                    m_reg = s[11:4];
                else if (gate && !m_prev)
                    m_reg = {m_reg[6:0], s[3]};
                m_prev = gate;
                pipe.push_back(cur);
            end
            chk(tag, q_last, m_reg[7]);
            chk("R9", q_last_n, ~m_reg[7]);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge sys_clk);
            #1;
        end
    endtask

    task automatic clk_pulse();
        shift_clk = 1'b0; cyc(4);
        shift_clk = 1'b1; cyc(4);
    endtask

    task automatic inh_pulse();
        clk_inh = 1'b1; cyc(4);
        clk_inh = 1'b0; cyc(4);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] sh;
        logic [7:0] serpat;
        rst_n = 1'b0; par_in = 8'h00; ser_in = 1'b1; load_n = 1'b1;
        shift_clk = 1'b1; clk_inh = 1'b0;
        cyc(5);
        chk("R1", q_last, 1'b0);
        chk("R1", q_last_n, 1'b1);
        rst_n = 1'b1;
        cyc(6);
        chk("R1", q_last, 1'b0);

        // R10 latency
        tag = "R10";
        par_in = 8'h80; load_n = 1'b0;
        @(negedge sys_clk); chk("R10", q_last, 1'b0);
        @(negedge sys_clk); chk("R10", q_last, 1'b0);
        @(negedge sys_clk); chk("R10", q_last, 1'b1);
        #1;

        // R4 follow while load low
        tag = "R4";
        par_in = 8'h00; cyc(4); chk("R4", q_last, 1'b0);
        par_in = 8'hFF; cyc(4); chk("R4", q_last, 1'b1);
        par_in = 8'h7F; cyc(4); chk("R4", q_last, 1'b0);

        // R3 clock/serial activity ignored during load
        tag = "R3";
        par_in = 8'h80;
        for (int i = 0; i < 3; i++) begin
            ser_in = i[0]; clk_pulse(); inh_pulse();
        end
        chk("R3", q_last, 1'b1);
        par_in = 8'h00; cyc(4); chk("R3", q_last, 1'b0);

        // R2 load then R11/R5 shift-out
        tag = "R2";
        shift_clk = 1'b1; clk_inh = 1'b0;
        par_in = 8'h5A; cyc(4);
        chk("R2", q_last, 1'b0);
        load_n = 1'b1; cyc(4);
        sh = 8'h5A;
        serpat = 8'b1100_1011;
        tag = "R11";
        for (int k = 0; k < 12; k++) begin
            ser_in = serpat[k % 8];
            clk_pulse();
            sh = {sh[6:0], serpat[k % 8]};
            chk("R11", q_last, sh[7]);
        end

        // R6 inhibit held high blocks shifting
        tag = "R6";
        shift_clk = 1'b1; cyc(4);
        clk_inh = 1'b1; cyc(4);
        for (int i = 0; i < 3; i++) begin
            ser_in = ~sh[7]; clk_pulse();
        end
        chk("R6", q_last, sh[7]);
        clk_inh = 1'b0; cyc(4);
        chk("R6", q_last, sh[7]);
        // clock held high blocks inhibit toggles
        inh_pulse(); inh_pulse();
        chk("R6", q_last, sh[7]);

        // R7 inhibit acts as clock while shift_clk low
        tag = "R7";
        shift_clk = 1'b0; cyc(4);
        for (int i = 0; i < 3; i++) begin
            ser_in = i[0];
            inh_pulse();
            sh = {sh[6:0], i[0]};
            chk("R7", q_last, sh[7]);
        end

        // R8 hold
        tag = "R8";
        ser_in = ~ser_in; cyc(20);
        chk("R8", q_last, sh[7]);

        // random pin activity against the model
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) shift_clk = ~shift_clk;
            if ($urandom_range(0, 11) == 0) clk_inh = ~clk_inh;
            if ($urandom_range(0, 3) == 0) ser_in = $urandom_range(0, 1);
            if ($urandom_range(0, 40) == 0) load_n = ~load_n;
            if ($urandom_range(0, 7) == 0) par_in = 8'($urandom);
            cyc(1);
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule